// File: doc/BRIEF.md
# Locality Access Arbiter

This block decides which of several software localities may use a shared command interface at a given time. Each locality sees its own copy of an access register at the base of its own 4 KiB address window. A locality writes that register to ask for the interface, to give it back, to take it from a lower-numbered owner, or to clear the flag that says it lost the interface. Reading the register shows, from that locality's view, whether it owns the interface, whether it was pushed out, whether it is waiting, and whether anyone else is waiting.

Requests that arrive while the interface is free are granted on the same clock edge that accepts the write. Requests that arrive while another locality owns the interface are held until the owner lets go. One clock after the release, the highest-numbered waiting locality gets the interface. A higher-numbered locality may also take the interface at once without waiting. The current owner is driven on plain output pins, so the command path next to this block can steer its traffic.

The register port is a plain strobe bus with no back-pressure. A write is accepted on every clock edge where `bus_wr` is high. A read strobe is always answered exactly one clock later with `bus_rvld` and `bus_rdata`. Only one access, read or write, is presented per cycle.

Top module: `loc_access_arbiter`

## Requirements
- R1: After reset no locality owns the interface: `active_vld` is 0, `owns` is all zeros, and no request or seized flag is set.
- R2: The access register of locality L is at byte address L*4096, where L is below NUM_LOC (default 5). A write anywhere else changes nothing. A read anywhere else returns 0x00.
- R3: A request (write with bit 1 set) from locality L while no locality owns the interface makes L the owner at the edge that accepts the write. `active_loc` then equals L and `owns` equals 1<<L.
- R4: A request from a non-owner while another locality owns the interface is queued, and bit 1 reads 1 in that locality's window. While any request is queued, bit 2 reads 1 in every window except the owner's, and reads 0 in the owner's window. A request from the owner itself is ignored.
- R5: The owner writing 1 to bit 5 gives up the interface. After that edge `active_vld` is 0 and bit 5 reads 0. A bit-5 write from a non-owner is ignored. Ownership changes only through register writes or the grant that follows a release.
- R6: One clock after a release, the highest-numbered queued locality becomes owner, and its bit 1 reads 0. If nothing is queued, the interface stays free.
- R7: A write with bit 3 set (seize) from a locality numbered higher than the owner makes it the owner at that edge. Bit 4 then reads 1 in the old owner's window, and the seizer's queued request is dropped.
- R8: A seize from a locality numbered lower than or equal to the owner is ignored. A seize while no locality owns the interface is also ignored.
- R9: Bit 4 stays 1 until that locality writes a 1 to bit 4. That write clears it, and writes with bit 4 clear leave it set.
- R10: A valid read returns bit 7 = 1, bit 0 = the ESTAB_BIT parameter (default 1), and bits 6 and 3 = 0. The data appears with `bus_rvld` one clock after `bus_rd`.
- R11: `owns` has at most one bit set, and that bit is the one at index `active_loc` when `active_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (16) | Byte address for the read or write |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid when bus_rvld is high |
| bus_rvld | output | 1 | Read data valid, one cycle after bus_rd |
| active_loc | output | LOC_W (3) | Number of the owning locality |
| active_vld | output | 1 | Some locality owns the interface |
| owns | output | NUM_LOC (5) | One-hot owner flag per locality |

## Verification
The queueing test runs every owner together with every subset of the other localities as requesters. It reads all windows to tell the owner's view of the pending flag apart from everyone else's view. It then drains the queue and checks that grants come in strictly descending order, one clock after each release.

The seize test runs every owner against every seizer. This separates a real takeover (higher number) from the ignored cases (lower number or the owner itself), and checks that the been-seized flag stays set until it is cleared. Further tests write to off-window addresses, to windows past the last locality, and send a release from a non-owner, to show that these change nothing visible.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

  // Bit positions of the per-locality access register; software decodes them.
  localparam int unsigned ACC_VALID   = 7;
  localparam int unsigned ACC_ACTIVE  = 5;
  localparam int unsigned ACC_SEIZED  = 4;
  localparam int unsigned ACC_SEIZE   = 3;
  localparam int unsigned ACC_PENDING = 2;
  localparam int unsigned ACC_REQUEST = 1;
  localparam int unsigned ACC_ESTAB   = 0;

  // Read image of the access register, most significant bit first.
  typedef struct packed {
    logic valid;
    logic rsvd6;
    logic active;
    logic seized;
    logic seize_rd;
    logic pending;
    logic request;
    logic estab;
  } acc_view_t;

endpackage

// File: rtl/loc_win_decode.sv
module loc_win_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_BITS = 12,
  parameter int unsigned NUM_LOC  = 5,
  parameter int unsigned LOC_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [LOC_W-1:0]  loc
);
  localparam int unsigned IDX_W = ADDR_W - WIN_BITS;

  logic [IDX_W-1:0] idx;

  // Upper address bits select the window; only offset zero is the register.
  assign idx = addr[ADDR_W-1:WIN_BITS];
  assign hit = (addr[WIN_BITS-1:0] == '0) && (idx < IDX_W'(NUM_LOC));
  assign loc = idx[LOC_W-1:0];
endmodule

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Highest set bit wins: later loop iterations overwrite earlier ones.
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/loc_owner_ctrl.sv
module loc_owner_ctrl
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [LOC_W-1:0]   wr_loc,
  input  logic [7:0]         wr_data,
  output logic               owner_vld,
  output logic [LOC_W-1:0]   owner,
  output logic [NUM_LOC-1:0] req,
  output logic [NUM_LOC-1:0] seized
);
  logic               own_vld_q, own_vld_d;
  logic [LOC_W-1:0]   own_q, own_d;
  logic [NUM_LOC-1:0] req_q, req_d, req_mid;
  logic [NUM_LOC-1:0] sz_q, sz_d;
  logic [NUM_LOC-1:0] wr_sel;
  logic               is_owner;
  logic               pick_any;
  logic [LOC_W-1:0]   pick_idx;

  // One-hot form of the writing locality.
  for (genvar g = 0; g < NUM_LOC; g++) begin : g_sel
    assign wr_sel[g] = wr_hit && (wr_loc == LOC_W'(g));
  end

  assign is_owner = own_vld_q && (wr_loc == own_q);

  // First pass: apply the write to the request and seized vectors.
  always_comb begin
    req_mid   = req_q;
    sz_d      = sz_q;
    own_vld_d = own_vld_q;
    own_d     = own_q;
    if (wr_hit) begin
      if (wr_data[ACC_SEIZED]) sz_d = sz_d & ~wr_sel;
      if (is_owner) begin
        if (wr_data[ACC_ACTIVE]) own_vld_d = 1'b0;
      end else if (wr_data[ACC_SEIZE] && own_vld_q && (wr_loc > own_q)) begin
        for (int i = 0; i < NUM_LOC; i++) begin
          if (own_q == LOC_W'(i)) sz_d[i] = 1'b1;
        end
        own_d   = wr_loc;
        req_mid = req_mid & ~wr_sel;
      end else if (wr_data[ACC_REQUEST]) begin
        req_mid = req_mid | wr_sel;
      end
    end
  end

  loc_prio_pick #(.N(NUM_LOC), .IDX_W(LOC_W)) u_pick (
    .vec (req_mid),
    .any (pick_any),
    .idx (pick_idx)
  );

  // Second pass: a free interface (as registered) goes to the top requester.
  always_comb begin
    req_d = req_mid;
    if (!own_vld_q && pick_any) begin
      for (int i = 0; i < NUM_LOC; i++) begin
        if (pick_idx == LOC_W'(i)) req_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_q     <= '0;
      req_q     <= '0;
      sz_q      <= '0;
    end else begin
      req_q <= req_d;
      sz_q  <= sz_d;
      if (!own_vld_q && pick_any) begin
        own_vld_q <= 1'b1;
        own_q     <= pick_idx;
      end else begin
        own_vld_q <= own_vld_d;
        own_q     <= own_d;
      end
    end
  end

  assign owner_vld = own_vld_q;
  assign owner     = own_q;
  assign req       = req_q;
  assign seized    = sz_q;
endmodule

// File: rtl/loc_read_port.sv
module loc_read_port
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned LOC_W     = 3,
  parameter logic        ESTAB_BIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               rd_hit,
  input  logic [LOC_W-1:0]   rd_loc,
  input  logic               owner_vld,
  input  logic [LOC_W-1:0]   owner,
  input  logic [NUM_LOC-1:0] req,
  input  logic [NUM_LOC-1:0] seized,
  output logic [7:0]         rdata,
  output logic               rvld
);
  acc_view_t view;
  logic      here_req, here_sz, here_own;

  always_comb begin
    here_req = 1'b0;
    here_sz  = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (rd_loc == LOC_W'(i)) begin
        here_req = req[i];
        here_sz  = seized[i];
      end
    end
  end

  assign here_own = owner_vld && (owner == rd_loc);

  always_comb begin
    view          = '0;
    view.valid    = 1'b1;
    view.active   = here_own;
    view.seized   = here_sz;
    view.pending  = (|req) && !here_own;
    view.request  = here_req;
    view.estab    = ESTAB_BIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      rvld  <= 1'b0;
    end else begin
      rvld <= rd_en;
      if (rd_en) rdata <= rd_hit ? view : 8'h00;
    end
  end
endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter #(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned WIN_BITS  = 12,
  parameter int unsigned ADDR_W    = 16,
  parameter logic        ESTAB_BIT = 1'b1,
  localparam int unsigned LOC_W    = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [7:0]         bus_rdata,
  output logic               bus_rvld,
  output logic [LOC_W-1:0]   active_loc,
  output logic               active_vld,
  output logic [NUM_LOC-1:0] owns
);
  logic               dec_hit;
  logic [LOC_W-1:0]   dec_loc;
  logic               own_vld;
  logic [LOC_W-1:0]   own_loc;
  logic [NUM_LOC-1:0] req_vec, sz_vec;

  loc_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NUM_LOC(NUM_LOC), .LOC_W(LOC_W)
  ) u_dec (
    .addr (bus_addr),
    .hit  (dec_hit),
    .loc  (dec_loc)
  );

  loc_owner_ctrl #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (bus_wr && dec_hit),
    .wr_loc    (dec_loc),
    .wr_data   (bus_wdata),
    .owner_vld (own_vld),
    .owner     (own_loc),
    .req       (req_vec),
    .seized    (sz_vec)
  );

  loc_read_port #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .ESTAB_BIT(ESTAB_BIT)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_rd),
    .rd_hit    (dec_hit),
    .rd_loc    (dec_loc),
    .owner_vld (own_vld),
    .owner     (own_loc),
    .req       (req_vec),
    .seized    (sz_vec),
    .rdata     (bus_rdata),
    .rvld      (bus_rvld)
  );

  assign active_vld = own_vld;
  assign active_loc = own_loc;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_owns
    assign owns[g] = own_vld && (own_loc == LOC_W'(g));
  end
endmodule

// File: rtl/loc_access_arbiter_chk.sv
module loc_access_arbiter_chk #(
  parameter int unsigned NUM_LOC  = 5,
  parameter int unsigned WIN_BITS = 12,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LOC_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [7:0]         bus_wdata,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [7:0]         bus_rdata,
  input logic               bus_rvld,
  input logic [LOC_W-1:0]   active_loc,
  input logic               active_vld,
  input logic [NUM_LOC-1:0] owns
);
  logic [ADDR_W-1:0] a_idx;
  logic              a_hit;
  logic [LOC_W-1:0]  a_loc;
  logic              w_hit;

  assign a_idx = bus_addr >> WIN_BITS;
  assign a_hit = (bus_addr[WIN_BITS-1:0] == '0) && (a_idx < ADDR_W'(NUM_LOC));
  assign a_loc = a_idx[LOC_W-1:0];
  assign w_hit = bus_wr && a_hit;

  AST_OWNS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owns)); // R11

  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (w_hit && bus_wdata[1] && !bus_wdata[3] && !active_vld) |=> active_vld); // R3

  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (w_hit && bus_wdata[5] && active_vld && (a_loc == active_loc)) |=> !active_vld); // R5

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_vld && !bus_wr) |=> (active_vld && $stable(active_loc))); // R5

  AST_SEIZE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (w_hit && bus_wdata[3] && active_vld && (a_loc > active_loc))
      |=> (active_vld && (active_loc == $past(a_loc)))); // R7

  AST_SEIZE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (w_hit && bus_wdata[3] && !bus_wdata[5] && active_vld && (a_loc <= active_loc))
      |=> (active_vld && $stable(active_loc))); // R8

  AST_READ_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && a_hit) |=> (bus_rvld && bus_rdata[7] && !bus_rdata[6] && !bus_rdata[3])); // R10
endmodule

bind loc_access_arbiter loc_access_arbiter_chk #(
  .NUM_LOC(NUM_LOC), .WIN_BITS(WIN_BITS), .ADDR_W(ADDR_W), .LOC_W(LOC_W)
) u_chk (.*);

// File: tb/loc_access_arbiter_tb_top.sv
module loc_access_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 5;
  localparam int AW         = 16;

  localparam logic [7:0] B_REQ   = 8'h02;
  localparam logic [7:0] B_SEIZE = 8'h08;
  localparam logic [7:0] B_CLRSZ = 8'h10;
  localparam logic [7:0] B_REL   = 8'h20;
  localparam logic [7:0] BASE    = 8'h81; // valid bit 7 + estab bit 0

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_rdata;
  logic          bus_rvld;
  logic [2:0]    active_loc;
  logic          active_vld;
  logic [N-1:0]  owns;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  loc_access_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvld(bus_rvld),
    .active_loc(active_loc), .active_vld(active_vld), .owns(owns)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic wr_acc(input int loc, input logic [7:0] d);
    wr_raw(AW'(loc) << 12, d);
  endtask

  task automatic rd_raw(input logic [AW-1:0] a, input string req, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    check(bus_rvld === 1'b1, {req, " rvld"}, int'(bus_rvld), 1);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic chk_win(input int loc, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd_raw(AW'(loc) << 12, req, d);
    check(d === exp, {req, " window read"}, int'(d), int'(exp));
  endtask

  task automatic chk_owner(input bit v, input int loc, input string req);
    logic [N-1:0] eo;
    eo = v ? (N'(1) << loc) : '0;
    check(active_vld === v, {req, " active_vld"}, int'(active_vld), int'(v));
    check(owns === eo, {req, " owns"}, int'(owns), int'(eo));
    if (v) check(active_loc === 3'(loc), {req, " active_loc"}, int'(active_loc), loc);
  endtask

  function automatic int top_bit(input int m);
    int h = -1;
    for (int i = 0; i < N; i++) if (m[i]) h = i;
    return h;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    do_reset();

    // R1 / R10: reset state and read format of every window
    chk_owner(1'b0, 0, "R1");
    for (int w = 0; w < N; w++) chk_win(w, BASE, "R1 R10");

    // R2: off-register and out-of-range addresses
    wr_raw(16'h2004, B_REQ);
    chk_owner(1'b0, 0, "R2 offset");
    wr_raw(16'h5000, B_REQ);
    chk_owner(1'b0, 0, "R2 window5");
    wr_raw(16'h9000, B_REQ);
    chk_owner(1'b0, 0, "R2 window9");
    rd_raw(16'h2004, "R2", d);
    check(d === 8'h00, "R2 offset read", int'(d), 0);
    rd_raw(16'h5000, "R2", d);
    check(d === 8'h00, "R2 window5 read", int'(d), 0);

    // R8: seize with no owner
    wr_acc(3, B_SEIZE);
    chk_owner(1'b0, 0, "R8 idle seize");

    // R5: release from a non-owner is ignored
    wr_acc(1, B_REQ);
    chk_owner(1'b1, 1, "R3");
    wr_acc(3, B_REL);
    chk_owner(1'b1, 1, "R5 non-owner release");
    wr_acc(1, B_REQ);
    chk_win(1, BASE | 8'h20, "R4 owner request ignored");

    // R3..R6: every owner with every subset of other requesters
    for (int o = 0; o < N; o++) begin
      for (int m = 0; m < (1 << N); m++) begin
        int cur, rem, h;
        if (m[o]) continue;
        do_reset();
        wr_acc(o, B_REQ);
        chk_owner(1'b1, o, "R3");
        for (int r = 0; r < N; r++) if (m[r]) wr_acc(r, B_REQ);
        chk_owner(1'b1, o, "R4 queued");
        for (int w = 0; w < N; w++) begin
          logic [7:0] e;
          e = BASE;
          if (w == o) e |= 8'h20;
          if (m != 0 && w != o) e |= 8'h04;
          if (m[w]) e |= 8'h02;
          chk_win(w, e, "R4");
        end
        cur = o; rem = m;
        while (rem != 0) begin
          wr_acc(cur, B_REL);
          chk_owner(1'b0, 0, "R5 release");
          @(negedge clk);
          h = top_bit(rem);
          chk_owner(1'b1, h, "R6 grant");
          rem[h] = 1'b0;
          cur = h;
        end
        chk_win(cur, BASE | 8'h20, "R6 granted request cleared");
        wr_acc(cur, B_REL);
        chk_owner(1'b0, 0, "R5 release");
        @(negedge clk);
        chk_owner(1'b0, 0, "R6 empty queue");
      end
    end

    // R7..R9: every owner against every seizer
    for (int o = 0; o < N; o++) begin
      for (int s = 0; s < N; s++) begin
        do_reset();
        wr_acc(o, B_REQ);
        if (s != o) wr_acc(s, B_REQ);
        wr_acc(s, B_SEIZE);
        if (s > o) begin
          chk_owner(1'b1, s, "R7 seize up");
          chk_win(o, BASE | 8'h10, "R7 old owner flag");
          chk_win(s, BASE | 8'h20, "R7 seizer request dropped");
          wr_acc(o, 8'h00);
          chk_win(o, BASE | 8'h10, "R9 flag persists");
          wr_acc(o, B_CLRSZ);
          chk_win(o, BASE, "R9 flag cleared");
        end else begin
          chk_owner(1'b1, o, "R8 seize ignored");
          chk_win(o, BASE | 8'h20, "R8 owner view");
          if (s != o) chk_win(s, BASE | 8'h06, "R8 seizer still queued");
        end
      end
    end

    finish_run();
  end
endmodule